// File: doc/BRIEF.md
# Dual-Port Memory Window Decoder

This block decides, for each of two address ports of a memory board, whether an incoming access falls inside the board's memory window. The primary system bus presents an address together with a 6-bit address-modifier code. The secondary local bus presents a plain 32-bit address. Each port has its own 12-bit base setting. The base setting gives the address bits from bit 20 upward, so the window always starts on a boundary equal to the board size.

The board size is a parameter, `SIZE_LOG2`, given as the log2 of the installed capacity in bytes: 20 for 1 MB and 21 for 2 MB. On a 2 MB board the lowest base bit has no effect. On the primary bus the modifier code chooses the width of the compare. A standard code compares only the low 24 address bits. An extended code compares all 32 bits. Any code outside the accepted set never selects the board.

When an access hits its window, the port raises a select pulse one clock after its strobe and presents the offset into the array at the same time. The offset is the address masked to the board size. Arbitration between the two ports and the data path are handled elsewhere.

Top module: `mem_window_decode`

## Requirements
- R1: On the primary port, modifier codes 0x39, 0x3A, 0x3D and 0x3E (standard) compare address bits [23:SIZE_LOG2] with the matching base bits. Address bits [31:24] and base bits [11:4] have no effect.
- R2: On the primary port, modifier codes 0x09, 0x0A, 0x0D and 0x0E (extended) compare address bits [31:SIZE_LOG2] with base bits [11:SIZE_LOG2-20].
- R3: Any other primary modifier code never raises the primary select, whatever the address and base.
- R4: With SIZE_LOG2=20, all 12 base bits take part in the compare. The window covers exactly one 1 MB block starting at base×2^20.
- R5: With SIZE_LOG2=21, base bit 0 is ignored. The window covers the 2 MB block that holds base×2^20.
- R6: The local port always compares address bits [31:SIZE_LOG2] against its own base setting. This is independent of the primary port's base and code.
- R7: On a hit, the select goes high in the cycle after the strobe. The offset output then equals address[SIZE_LOG2-1:0] from the strobe cycle. The offset keeps its value until the next hit.
- R8: A select is raised only for a cycle whose strobe was high. With the strobe low, the select stays low even when the address matches.
- R9: While reset is asserted, both selects are low and both offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_strobe | input | 1 | Primary port access strobe |
| pri_am | input | 6 | Primary address-modifier code |
| pri_addr | input | 32 | Primary address |
| pri_base | input | 12 | Primary window base (address bits 31:20) |
| loc_strobe | input | 1 | Local port access strobe |
| loc_addr | input | 32 | Local address |
| loc_base | input | 12 | Local window base (address bits 31:20) |
| pri_sel | output | 1 | Primary select pulse |
| pri_off | output | SIZE_LOG2 | Primary array offset |
| loc_sel | output | 1 | Local select pulse |
| loc_off | output | SIZE_LOG2 | Local array offset |

## Verification
The assertions check the following on every cycle:
- A select always follows a strobe.
- An offset changes only together with a select.
- A primary select never follows an unaccepted code.
- Every select that is raised matched the correct address slice, either 24-bit or 32-bit, for its code and port.

Some behaviours can be shown only by the bench's scenarios:
- That a matching access is actually selected and not missed.
- The exact window edges for each board size.
- That upper address and base bits are ignored in standard mode.
- That the two ports' bases stay independent.

// File: rtl/mem_window_pkg.sv
package mem_window_pkg;

  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_STD  = 2'd1,
    AM_EXT  = 2'd2
  } am_kind_e;

  // Standard (24-bit) and extended (32-bit) program/data codes,
  // supervisory and non-privileged.
  function automatic am_kind_e am_classify(input logic [5:0] code);
    am_kind_e k;
    case (code)
      6'h39, 6'h3A, 6'h3D, 6'h3E: k = AM_STD;
      6'h09, 6'h0A, 6'h0D, 6'h0E: k = AM_EXT;
      default:                    k = AM_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/am_classify.sv
module am_classify
  import mem_window_pkg::*;
(
  input  logic [5:0] am,
  output am_kind_e   kind,
  output logic       narrow
);

  always_comb begin
    kind   = am_classify(am);
    narrow = (kind == AM_STD);
  end

endmodule

// File: rtl/win_cmp.sv
module win_cmp #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 20,
  parameter int NARROW_W  = 24
) (
  input  logic [ADDR_W-1:SIZE_LOG2] addr_hi,
  input  logic [ADDR_W-1:SIZE_LOG2] base_hi,
  input  logic                      narrow,
  output logic                      hit
);

  localparam int HI_W     = ADDR_W - SIZE_LOG2;
  localparam int NARROW_HI = NARROW_W - SIZE_LOG2;

  logic [HI_W-1:0] a_v;
  logic [HI_W-1:0] b_v;
  logic            wide_eq;
  logic            narrow_eq;

  always_comb begin
    a_v       = addr_hi;
    b_v       = base_hi;
    wide_eq   = (a_v == b_v);
    narrow_eq = (a_v[NARROW_HI-1:0] == b_v[NARROW_HI-1:0]);
    hit       = narrow ? narrow_eq : wide_eq;
  end

endmodule

// File: rtl/sel_stage.sv
module sel_stage #(
  parameter int OFF_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             hit,
  input  logic [OFF_W-1:0] off_in,
  output logic             sel,
  output logic [OFF_W-1:0] off
);

  logic             sel_d;
  logic             off_en;
  logic [OFF_W-1:0] off_d;

  always_comb begin
    sel_d  = strobe & hit;
    off_en = sel_d;
    off_d  = off_en ? off_in : off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 1'b0;
      off <= '0;
    end else begin
      sel <= sel_d;
      off <= off_d;
    end
  end

  p_sel_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> $past(strobe));

  p_off_moves_with_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off) |-> sel);

endmodule

// File: rtl/mem_window_decode.sv
module mem_window_decode
  import mem_window_pkg::*;
#(
  parameter int SIZE_LOG2 = 20,
  parameter int ADDR_W    = 32,
  parameter int BASE_W    = 12,
  parameter int NARROW_W  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pri_strobe,
  input  logic [5:0]           pri_am,
  input  logic [31:0]          pri_addr,
  input  logic [11:0]          pri_base,
  input  logic                 loc_strobe,
  input  logic [31:0]          loc_addr,
  input  logic [11:0]          loc_base,
  output logic                 pri_sel,
  output logic [SIZE_LOG2-1:0] pri_off,
  output logic                 loc_sel,
  output logic [SIZE_LOG2-1:0] loc_off
);

  localparam int BASE_LSB = ADDR_W - BASE_W;     // address bit of base bit 0
  localparam int SKIP     = SIZE_LOG2 - BASE_LSB; // base bits below board size

  am_kind_e pri_kind;
  logic     pri_narrow;
  logic     pri_hit;
  logic     loc_hit;

  logic [ADDR_W-1:SIZE_LOG2] pri_base_hi;
  logic [ADDR_W-1:SIZE_LOG2] loc_base_hi;

  always_comb begin
    pri_base_hi = pri_base[BASE_W-1:SKIP];
    loc_base_hi = loc_base[BASE_W-1:SKIP];
  end

  generate
    if (SKIP > 0) begin : g_skip
      logic unused_base_low;
      assign unused_base_low = ^{pri_base[SKIP-1:0], loc_base[SKIP-1:0]};
    end
  endgenerate

  am_classify u_cls (
    .am     (pri_am),
    .kind   (pri_kind),
    .narrow (pri_narrow)
  );

  win_cmp #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2), .NARROW_W(NARROW_W)) u_pri_cmp (
    .addr_hi (pri_addr[ADDR_W-1:SIZE_LOG2]),
    .base_hi (pri_base_hi),
    .narrow  (pri_narrow),
    .hit     (pri_hit)
  );

  win_cmp #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2), .NARROW_W(NARROW_W)) u_loc_cmp (
    .addr_hi (loc_addr[ADDR_W-1:SIZE_LOG2]),
    .base_hi (loc_base_hi),
    .narrow  (1'b0),
    .hit     (loc_hit)
  );

  sel_stage #(.OFF_W(SIZE_LOG2)) u_pri_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (pri_strobe & (pri_kind != AM_NONE)),
    .hit    (pri_hit),
    .off_in (pri_addr[SIZE_LOG2-1:0]),
    .sel    (pri_sel),
    .off    (pri_off)
  );

  sel_stage #(.OFF_W(SIZE_LOG2)) u_loc_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (loc_strobe),
    .hit    (loc_hit),
    .off_in (loc_addr[SIZE_LOG2-1:0]),
    .sel    (loc_sel),
    .off    (loc_off)
  );

  p_known_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pri_sel |-> $past(pri_kind != AM_NONE));

  p_std_low_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_sel && $past(pri_kind == AM_STD)) |->
      ($past(pri_addr[NARROW_W-1:SIZE_LOG2]) == $past(pri_base[NARROW_W-1-BASE_LSB:SKIP])));

  p_ext_full_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_sel && $past(pri_kind == AM_EXT)) |->
      ($past(pri_addr[ADDR_W-1:SIZE_LOG2]) == $past(pri_base[BASE_W-1:SKIP])));

  p_loc_full_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_sel |-> ($past(loc_addr[ADDR_W-1:SIZE_LOG2]) == $past(loc_base[BASE_W-1:SKIP])));

endmodule

// File: tb/tb_mem_window_decode.sv
module tb_mem_window_decode;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        pri_strobe;
  logic [5:0]  pri_am;
  logic [31:0] pri_addr;
  logic [11:0] pri_base;
  logic        loc_strobe;
  logic [31:0] loc_addr;
  logic [11:0] loc_base;

  logic        s_pri_sel, s_loc_sel, b_pri_sel, b_loc_sel;
  logic [19:0] s_pri_off, s_loc_off;
  logic [20:0] b_pri_off, b_loc_off;

  int checks;
  int failures;

  // expected offset state: [0] small pri, [1] small loc, [2] big pri, [3] big loc
  logic [31:0] exp_off [4];

  mem_window_decode #(.SIZE_LOG2(20)) dut (
    .clk(clk), .rst_n(rst_n),
    .pri_strobe(pri_strobe), .pri_am(pri_am), .pri_addr(pri_addr), .pri_base(pri_base),
    .loc_strobe(loc_strobe), .loc_addr(loc_addr), .loc_base(loc_base),
    .pri_sel(s_pri_sel), .pri_off(s_pri_off), .loc_sel(s_loc_sel), .loc_off(s_loc_off)
  );

  mem_window_decode #(.SIZE_LOG2(21)) dut2 (
    .clk(clk), .rst_n(rst_n),
    .pri_strobe(pri_strobe), .pri_am(pri_am), .pri_addr(pri_addr), .pri_base(pri_base),
    .loc_strobe(loc_strobe), .loc_addr(loc_addr), .loc_base(loc_base),
    .pri_sel(b_pri_sel), .pri_off(b_pri_off), .loc_sel(b_loc_sel), .loc_off(b_loc_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_hit(int lg, bit is_pri, logic [5:0] am,
                                 logic [31:0] addr, logic [11:0] base);
    logic [31:0] start;
    logic [31:0] mask;
    start = {base, 20'h0};
    mask  = ~((32'h1 << lg) - 32'h1);
    if (is_pri) begin
      if (am == 6'h39 || am == 6'h3A || am == 6'h3D || am == 6'h3E)
        mask = mask & 32'h00FF_FFFF;
      else if (!(am == 6'h09 || am == 6'h0A || am == 6'h0D || am == 6'h0E))
        return 1'b0;
    end
    return ((addr ^ start) & mask) == 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag, bit e0, bit e1, bit e2, bit e3);
    check({tag, " small pri sel"}, {31'h0, s_pri_sel}, {31'h0, e0});
    check({tag, " small loc sel"}, {31'h0, s_loc_sel}, {31'h0, e1});
    check({tag, " big pri sel"},   {31'h0, b_pri_sel}, {31'h0, e2});
    check({tag, " big loc sel"},   {31'h0, b_loc_sel}, {31'h0, e3});
    check({tag, " small pri off"}, {12'h0, s_pri_off}, exp_off[0]);
    check({tag, " small loc off"}, {12'h0, s_loc_off}, exp_off[1]);
    check({tag, " big pri off"},   {11'h0, b_pri_off}, exp_off[2]);
    check({tag, " big loc off"},   {11'h0, b_loc_off}, exp_off[3]);
  endtask

  // one strobed access on both ports, checked one cycle later
  task automatic probe(string tag, logic [5:0] am, logic [31:0] pa, logic [11:0] pb,
                       logic [31:0] la, logic [11:0] lb);
    bit e [4];
    @(negedge clk);
    pri_strobe = 1'b1; pri_am = am; pri_addr = pa; pri_base = pb;
    loc_strobe = 1'b1; loc_addr = la; loc_base = lb;
    e[0] = exp_hit(20, 1'b1, am, pa, pb);
    e[1] = exp_hit(20, 1'b0, am, la, lb);
    e[2] = exp_hit(21, 1'b1, am, pa, pb);
    e[3] = exp_hit(21, 1'b0, am, la, lb);
    if (e[0]) exp_off[0] = pa & 32'h000F_FFFF;
    if (e[1]) exp_off[1] = la & 32'h000F_FFFF;
    if (e[2]) exp_off[2] = pa & 32'h001F_FFFF;
    if (e[3]) exp_off[3] = la & 32'h001F_FFFF;
    @(negedge clk);
    pri_strobe = 1'b0; loc_strobe = 1'b0;
    check_outputs(tag, e[0], e[1], e[2], e[3]);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    pri_strobe = 1'b1; pri_am = 6'h0D; pri_addr = 32'h0; pri_base = 12'h0;
    loc_strobe = 1'b1; loc_addr = 32'h0; loc_base = 12'h0;
    for (int i = 0; i < 4; i++) exp_off[i] = 32'h0;
    repeat (3) @(negedge clk);
    check_outputs("R9 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    pri_strobe = 1'b0; loc_strobe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_standard;
    probe("R1 std 0x39 upper addr ignored", 6'h39, 32'hAB51_2345, 12'h005, 32'h0, 12'hFFF);
    probe("R1 std 0x3E upper base ignored", 6'h3E, 32'h0051_0000, 12'hF05, 32'h0, 12'hFFF);
    probe("R1 std 0x3A low window miss",   6'h3A, 32'h0061_0000, 12'h005, 32'h0, 12'hFFF);
    probe("R1 std 0x3D hit",               6'h3D, 32'h00A0_0042, 12'h70A, 32'h0, 12'hFFF);
  endtask

  task automatic test_extended;
    probe("R2 ext 0x0D hit",          6'h0D, 32'h1230_0010, 12'h123, 32'h0, 12'hFFF);
    probe("R2 ext 0x09 base differs", 6'h09, 32'h1230_0010, 12'h923, 32'h0, 12'hFFF);
    probe("R2 ext 0x0A upper differs",6'h0A, 32'hA230_0010, 12'h123, 32'h0, 12'hFFF);
    probe("R2 ext 0x0E hit",          6'h0E, 32'hFFFF_FFFF, 12'hFFF, 32'h0, 12'hFFF);
  endtask

  task automatic test_bad_codes;
    logic [5:0] codes [6];
    codes = '{6'h3B, 6'h29, 6'h2D, 6'h00, 6'h3F, 6'h0B};
    foreach (codes[i])
      probe("R3 rejected code", codes[i], 32'h0050_0100, 12'h005, 32'h0, 12'hFFF);
  endtask

  task automatic test_small_edges;
    probe("R4 below window",    6'h0D, 32'h004F_FFFF, 12'h005, 32'h0, 12'hFFF);
    probe("R4 first byte",      6'h0D, 32'h0050_0000, 12'h005, 32'h0, 12'hFFF);
    probe("R4 last byte",       6'h0D, 32'h005F_FFFF, 12'h005, 32'h0, 12'hFFF);
    probe("R4 above window",    6'h0D, 32'h0060_0000, 12'h005, 32'h0, 12'hFFF);
  endtask

  task automatic test_big_edges;
    probe("R5 base bit0 ignored low",  6'h0D, 32'h0040_0010, 12'h005, 32'h0, 12'hFFF);
    probe("R5 last byte of 2MB",       6'h0D, 32'h005F_FFFF, 12'h004, 32'h0, 12'hFFF);
    probe("R5 past 2MB window",        6'h0D, 32'h0060_0000, 12'h005, 32'h0, 12'hFFF);
  endtask

  task automatic test_local;
    probe("R6 local hit other base",  6'h00, 32'h0, 12'h001, 32'h8001_2345, 12'h800);
    probe("R6 local upper bits count",6'h39, 32'h0, 12'h800, 32'h0001_2345, 12'h800);
    probe("R6 both ports independent",6'h0D, 32'h0030_0007, 12'h003, 32'h7FF5_4321, 12'h7FF);
  endtask

  task automatic test_hold_and_idle;
    probe("R7 hit loads offset",  6'h0D, 32'h0230_0ABC, 12'h023, 32'h0450_0DEF, 12'h045);
    probe("R7 miss holds offset", 6'h0D, 32'h0990_0000, 12'h023, 32'h0990_0000, 12'h045);
    @(negedge clk);
    pri_am = 6'h0D; pri_addr = 32'h0230_0001; pri_base = 12'h023;
    loc_addr = 32'h0450_0002; loc_base = 12'h045;
    pri_strobe = 1'b0; loc_strobe = 1'b0;
    @(negedge clk);
    check_outputs("R8 no strobe no select", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    test_reset();
    test_standard();
    test_extended();
    test_bad_codes();
    test_small_edges();
    test_big_edges();
    test_local();
    test_hold_and_idle();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule